// File: doc/BRIEF.md
# Split-Parity Look-Ahead Adder

This block is a purely combinational binary adder built from 8-bit slices. Inside each slice the carry logic is not one long chain. Every bit first forms three local terms: both-ones (generate), either-one (OR-propagate) and exactly-one (XOR-propagate). Adjacent bits are then merged into pair terms. Two separate look-ahead networks, each four terms deep, turn the pair terms into pseudo-carries. One network serves the even bit positions and the other serves the odd ones, and they share no intermediate signal. The true carry of a bit is its pseudo-carry gated by its OR-propagate. Each sum bit above bit 0 comes from a 2:1 selection steered by the pseudo-carry of the bit below it.

The top level stacks `WIDTH/8` slices. The carry-out of each slice feeds the carry-in of the next, so widths of 16, 32 or 64 bits are built from two, four or eight slices. A width that is not a multiple of 8 stops elaboration with an error. The block has no clock and no state. Besides the sum and the final carry, it brings out the true carry of every bit position, so that a caller, or a test, can see the carry vector. There is no data stream here, so the ports carry no handshake: operands in, results out in the same evaluation.

Top module: `dcl_adder`

## Requirements
- R1: For an 8-bit instance, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every one of the 2^17 input combinations.
- R2: `carry_o[i]` is the carry leaving bit position i, i.e. the carry into position i+1 of a plain bit-serial ripple addition of `a_i`, `b_i` and `cin_i`, for every i from 0 to WIDTH-1.
- R3: `cout_o` equals bit WIDTH of the full-precision sum `a_i + b_i + cin_i`.
- R4: When `a_i ^ b_i` is all ones, a carry-in of 1 yields `sum_o` = 0, `cout_o` = 1 and `carry_o` all ones. A carry-in of 0 yields `sum_o` all ones, `cout_o` = 0 and `carry_o` = 0. This holds across every slice boundary.
- R5: With both operands zero, `cin_i` = 0 gives `sum_o` = 0, `cout_o` = 0 and `carry_o` = 0, while `cin_i` = 1 gives `sum_o` = 1 and `carry_o` = 0.
- R6: For the cascaded WIDTH-bit adder, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for random operands and for alternating-bit patterns (0xAA.. and 0x55..).
- R7: At any bit where both operands are 1, `carry_o` at that bit is 1. At any bit where both operands are 0, it is 0. This holds whatever the carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| cout_o | output | 1 | Carry out of the most significant bit |
| carry_o | output | WIDTH | True carry leaving each bit position |

## Verification
On every evaluation, the embedded assertions check four things. Each slice's result must match arithmetic addition, and the whole cascade's result must match it too. The pair-grouped generate and propagate terms must never both be high at the same position. Each flattened look-ahead output must equal the one-step recursion from its neighbour in the same chain. Finally, generate and kill bits must force the carry they imply. What only the bench's scenarios can show is that the exposed carry vector agrees bit for bit with an independent ripple model. That matters because a fault in the pseudo-carry or gating logic can leave some sums unchanged. The bench also shows that every one of the 2^17 slice inputs is covered, and that full-length propagation across all slice boundaries settles to the right values.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
  // width of one adder slice; each slice holds two chains of half this length
  localparam int SLICE_W   = 8;
  localparam int CHAIN_LEN = SLICE_W / 2;
endpackage

// File: rtl/dcl_chain.sv
// Four-term look-ahead network producing pseudo-carries for one parity class.
// Output k is the OR over j<=k of (grp_g[j] AND grp_p[j+1..k]) plus the seed
// term (seed AND grp_p[0..k]), written in flattened sum-of-products form.
module dcl_chain #(
  parameter int LEN = 4
) (
  input  logic [LEN-1:0] grp_g_i,
  input  logic [LEN-1:0] grp_p_i,
  input  logic           seed_i,
  output logic [LEN-1:0] h_o
);

  always_comb begin
    logic acc;
    logic term;
    for (int k = 0; k < LEN; k++) begin
      acc = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = grp_g_i[j];
        for (int m = j + 1; m <= k; m++) begin
          term = term & grp_p_i[m];
        end
        acc = acc | term;
      end
      term = seed_i;
      for (int m = 0; m <= k; m++) begin
        term = term & grp_p_i[m];
      end
      h_o[k] = acc | term;
    end
  end

  // each flattened output must agree with a single recursive step
  for (genvar k = 0; k < LEN; k++) begin : g_rec
    logic prev_h;
    if (k == 0) begin : g_base
      assign prev_h = seed_i;
    end else begin : g_step
      assign prev_h = h_o[k-1];
    end
    always_comb begin
      // R2
      chain_recur_chk: assert (h_o[k] == (grp_g_i[k] | (grp_p_i[k] & prev_h)))
        else $error("pseudo-carry %0d breaks recursion", k);
    end
  end

endmodule

// File: rtl/dcl_recover.sv
// Turns pseudo-carries back into true carries and sum bits (2:1 select per bit).
module dcl_recover #(
  parameter int W = 8
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] h_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o,
  output logic         cout_o
);

  assign carry_o = t_i & h_i;
  assign cout_o  = carry_o[W-1];

  for (genvar i = 0; i < W; i++) begin : g_sum
    if (i == 0) begin : g_lsb
      assign sum_o[i] = p_i[i] ^ cin_i;
    end else begin : g_upper
      logic flip;
      assign flip     = p_i[i] ^ t_i[i-1];
      assign sum_o[i] = h_i[i-1] ? flip : p_i[i];
    end
  end

endmodule

// File: rtl/dcl_slice.sv
// One 8-bit slice: bit terms, pair-grouped terms, even and odd chains, recovery.
module dcl_slice #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic [W-1:0] carry_o
);

  localparam int HALF = W / 2;

  logic [W-1:0] gen_b, orp_b, xop_b;
  logic [W-1:0] grp_g, grp_p;
  logic [W-1:0] h;
  logic [HALF-1:0] ev_g, ev_p, ev_h;
  logic [HALF-1:0] od_g, od_p, od_h;

  assign gen_b = a_i & b_i;
  assign orp_b = a_i | b_i;
  assign xop_b = a_i ^ b_i;

  // pair terms: below bit 0 the generate is the carry-in, the OR-propagate is 1
  for (genvar i = 0; i < W; i++) begin : g_pair
    if (i == 0) begin : g_b0
      assign grp_g[i] = gen_b[i] | cin_i;
      assign grp_p[i] = 1'b0;
    end else if (i == 1) begin : g_b1
      assign grp_g[i] = gen_b[i] | gen_b[i-1];
      assign grp_p[i] = xop_b[i] & xop_b[i-1];
    end else begin : g_bn
      assign grp_g[i] = gen_b[i] | gen_b[i-1];
      assign grp_p[i] = xop_b[i] & xop_b[i-1] & orp_b[i-2];
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_split
    assign ev_g[k]     = grp_g[2*k];
    assign ev_p[k]     = grp_p[2*k];
    assign od_g[k]     = grp_g[2*k+1];
    assign od_p[k]     = grp_p[2*k+1];
    assign h[2*k]      = ev_h[k];
    assign h[2*k+1]    = od_h[k];
  end

  // even chain: carry-in already folded into its first pair term
  dcl_chain #(.LEN(HALF)) u_even (
    .grp_g_i (ev_g),
    .grp_p_i (ev_p),
    .seed_i  (1'b0),
    .h_o     (ev_h)
  );

  dcl_chain #(.LEN(HALF)) u_odd (
    .grp_g_i (od_g),
    .grp_p_i (od_p),
    .seed_i  (cin_i),
    .h_o     (od_h)
  );

  dcl_recover #(.W(W)) u_rec (
    .p_i     (xop_b),
    .t_i     (orp_b),
    .h_i     (h),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .carry_o (carry_o),
    .cout_o  (cout_o)
  );

  always_comb begin
    // R1
    slice_sum_chk: assert ({cout_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
      else $error("slice sum mismatch");
    // R2
    pair_excl_chk: assert ((grp_g & grp_p) == '0)
      else $error("pair generate and propagate overlap");
    // R3
    slice_cout_chk: assert (cout_o == (gen_b[W-1] | (xop_b[W-1] & carry_o[W-2])))
      else $error("slice carry-out inconsistent");
    // R7
    gen_kill_chk: assert (((gen_b & ~carry_o) == '0) && ((~orp_b & carry_o) == '0))
      else $error("generate or kill bit ignored");
  end

endmodule

// File: rtl/dcl_adder.sv
// WIDTH-bit adder built by rippling slice carries.
module dcl_adder
  import dcl_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic [WIDTH-1:0] carry_o
);

  localparam int NSLICE = WIDTH / SLICE_W;

  if ((WIDTH % SLICE_W) != 0 || WIDTH < SLICE_W) begin : g_bad_width
    $error("dcl_adder: WIDTH must be a positive multiple of the slice width");
  end

  for (genvar k = 0; k < NSLICE; k++) begin : g_slc
    logic cin_k;
    logic cout_k;
    if (k == 0) begin : g_first
      assign cin_k = cin_i;
    end else begin : g_next
      assign cin_k = g_slc[k-1].cout_k;
    end
    dcl_slice #(.W(SLICE_W)) u_slice (
      .a_i     (a_i[k*SLICE_W +: SLICE_W]),
      .b_i     (b_i[k*SLICE_W +: SLICE_W]),
      .cin_i   (cin_k),
      .sum_o   (sum_o[k*SLICE_W +: SLICE_W]),
      .cout_o  (cout_k),
      .carry_o (carry_o[k*SLICE_W +: SLICE_W])
    );
  end

  assign cout_o = g_slc[NSLICE-1].cout_k;

  always_comb begin
    // R6
    total_sum_chk: assert ({cout_o, sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
      else $error("cascade sum mismatch");
  end

endmodule

// File: tb/dcl_adder_tb.sv
module dcl_adder_tb;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] a64, b64, s64, c64;
  logic        cin64, co64;
  logic [7:0]  a8, b8, s8, c8;
  logic        cin8, co8;

  dcl_adder #(.WIDTH(64)) u_dut (
    .a_i(a64), .b_i(b64), .cin_i(cin64),
    .sum_o(s64), .cout_o(co64), .carry_o(c64)
  );

  dcl_adder #(.WIDTH(8)) u_dut8 (
    .a_i(a8), .b_i(b8), .cin_i(cin8),
    .sum_o(s8), .cout_o(co8), .carry_o(c8)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // bit-serial reference: sum bits and the carry leaving each position
  function automatic void ripple(input logic [63:0] a, input logic [63:0] b,
                                 input logic ci, output logic [63:0] s,
                                 output logic [63:0] c);
    logic cy;
    cy = ci;
    for (int i = 0; i < 64; i++) begin
      s[i] = a[i] ^ b[i] ^ cy;
      cy   = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
      c[i] = cy;
    end
  endfunction

  task automatic vec64(input logic [63:0] a, input logic [63:0] b,
                       input logic ci, input string sum_req);
    logic [63:0] es, ec, gm, km;
    @(posedge clk);
    a64 = a; b64 = b; cin64 = ci;
    @(negedge clk);
    ripple(a, b, ci, es, ec);
    gm = a & b;
    km = ~a & ~b;
    check(s64 == es, sum_req, "sum64", s64, es);
    check(co64 == ec[63], "R3", "cout64", 64'(co64), 64'(ec[63]));
    check(c64 == ec, "R2", "carry64", c64, ec);
    check(((c64 & gm) == gm) && ((c64 & km) == 64'd0), "R7", "gen/kill64", c64, ec);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired act=%0d exp=%0d", n_chk, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] es, ec, ra, rb;
    void'($urandom(32'd5150));
    a64 = '0; b64 = '0; cin64 = 1'b0;
    a8 = '0; b8 = '0; cin8 = 1'b0;

    // R5 zero operands
    vec64(64'd0, 64'd0, 1'b0, "R5");
    check(s64 == 64'd0 && co64 == 1'b0, "R5", "zero-all", s64, 64'd0);
    vec64(64'd0, 64'd0, 1'b1, "R5");
    check(s64 == 64'd1 && c64 == 64'd0, "R5", "zero-cin", s64, 64'd1);

    // R4 full-length propagate across every slice boundary
    vec64({64{1'b1}}, 64'd0, 1'b1, "R4");
    check(s64 == 64'd0 && co64 && c64 == {64{1'b1}}, "R4", "ones+cin", c64, {64{1'b1}});
    vec64({32{2'b10}}, {32{2'b01}}, 1'b1, "R4");
    check(s64 == 64'd0 && co64 && c64 == {64{1'b1}}, "R4", "alt+cin", c64, {64{1'b1}});
    vec64({32{2'b10}}, {32{2'b01}}, 1'b0, "R4");
    check(s64 == {64{1'b1}} && !co64 && c64 == 64'd0, "R4", "alt-nocin", s64, {64{1'b1}});
    vec64({64{1'b1}}, {64{1'b1}}, 1'b1, "R6");
    vec64({32{2'b10}}, {32{2'b10}}, 1'b0, "R6");
    vec64({32{2'b01}}, {32{2'b01}}, 1'b1, "R6");

    // R1 / R2 exhaustive slice
    for (int v = 0; v < (1 << 17); v++) begin
      @(posedge clk);
      {cin8, a8, b8} = 17'(v);
      @(negedge clk);
      ripple(64'(a8), 64'(b8), cin8, es, ec);
      check({co8, s8} == {ec[7], es[7:0]}, "R1", "slice-sum",
            64'({co8, s8}), 64'({ec[7], es[7:0]}));
      check(c8 == ec[7:0], "R2", "slice-carry", 64'(c8), 64'(ec[7:0]));
    end

    // R6 random and patterned cascade vectors
    for (int n = 0; n < 1500; n++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      case (n % 4)
        1: rb = ~ra ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        2: begin ra = ra | {32{2'b10}}; rb = rb & {32{2'b01}}; end
        default: ;
      endcase
      vec64(ra, rb, 1'($urandom), "R6");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule